// File: doc/BRIEF.md
# Program counter and stack sequencer

This block holds the program counter and the stack pointer of a single-cycle 8-bit processor. Instructions are one or two bytes long. Each cycle it receives the opcode byte, the second instruction byte, the current flags, a register value and the memory read data. From these it forms the next PC and the next SP, and it drives a memory address with write data whenever something is pushed. It covers sequential advance, direct and register-indirect jumps, conditional jumps, subroutine call and return, push, pop and halt. The ALU and the general register file sit outside the block. The block names the register it needs on `reg_idx_o`, and the register file answers on `reg_val_i` in the same cycle.

The stack is full-descending. A push pre-decrements SP and writes at the new SP. A pop reads at SP and then increments it. Address 0xFF is not RAM. A read there returns the switch input port, and a write there is dropped. A halt is sticky until reset. It comes either from the halt opcode, which takes effect in the same cycle, or from the H bit of the flags register, which the surrounding datapath sets with a flags write, so it takes effect one cycle after that write.

Top module: `pc_stack_seq`

## Requirements
- R1: After the asynchronous active-low reset, `pc_o` is 0x00, `sp_o` is 0xFF and `halt_o` is 0.
- R2: Opcodes 0x00, 0x01, 0x0F and the patterns 10100rrr, 11010rrr, 11100rrr and 11110rrr are one byte long. Every other opcode is two bytes long, including opcodes with no defined meaning. A non-control instruction advances the PC by its length.
- R3: Opcode 0x02 loads the PC with the second byte. Opcode 0x03 puts bits [2:0] of the second byte on `reg_idx_o` and loads the PC with `reg_val_i`. Index 7 means the stack pointer, so the current SP is used for it.
- R4: `flags_i` bit 7 is C, bit 6 is Z, bit 5 is S and bit 4 is V. The opcode pairs 0x04/0x05 test C, 0x06/0x07 test Z, 0x0A/0x0B test S and 0x0C/0x0D test V. The even opcode jumps to the second byte when its flag is 1, and the odd opcode jumps when its flag is 0. A jump that is not taken advances the PC by 2.
- R5: Opcode 0x0E (call) writes PC+2 to address SP-1, sets SP to SP-1 and loads the PC with the second byte.
- R6: Opcode 0x0F (return) reads address SP, loads the PC with the data read (`rd_data_o`) and increments SP.
- R7: Opcode 11100rrr (push) puts rrr on `reg_idx_o`, writes the register value to SP-1 and decrements SP. Register 7 is the SP value before the push. Opcode 11110rrr (pop) reads address SP onto `rd_data_o` and increments SP. Both advance the PC by 1.
- R8: A read at address 0xFF returns `sw_i`. A write aimed at 0xFF does not assert `mem_we_o`, but SP still moves.
- R9: Opcode 0x00 raises `halt_o` in the same cycle and the PC keeps its value.
- R10: When `flags_i` bit 3 (H) is 1, `halt_o` rises and the PC and SP hold. From then until reset, the block stays halted and never writes memory, even if H clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 8 | First instruction byte |
| operand_i | input | W | Second instruction byte (address or register index) |
| flags_i | input | 8 | Flags register value: C,Z,S,V,H in bits 7..3 |
| reg_val_i | input | W | Register file read data for `reg_idx_o` |
| mem_rdata_i | input | W | RAM read data at `mem_addr_o` |
| sw_i | input | W | Switch input port seen at address 0xFF |
| reg_idx_o | output | 3 | Register index requested from the register file |
| pc_o | output | W | Program counter |
| sp_o | output | W | Stack pointer |
| mem_addr_o | output | W | Stack memory address |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_wdata_o | output | W | Stack memory write data |
| rd_data_o | output | W | Read data after the switch-port substitution (pop/return value) |
| halt_o | output | 1 | Halt indication |

## Verification
A wrong PC shows at `pc_o` on the next clock edge after the faulty instruction. A wrong SP shows at once as a wrong `mem_addr_o` in a push or pop, and as a wrong `sp_o` one edge later. A corrupted stack entry stays hidden until the matching return, so calls nested two deep are unwound and each return target is compared. A lost halt shows as `pc_o` moving on the following edge. The same applies to a halt that is not sticky, which moves the PC one cycle after H clears.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int OPW = 8;
  localparam int RIW = 3;
  localparam int FLAG_C = 7;
  localparam int FLAG_Z = 6;
  localparam int FLAG_S = 5;
  localparam int FLAG_V = 4;
  localparam int FLAG_H = 3;

  typedef enum logic [3:0] {
    K_SEQ, K_HALT, K_JMPI, K_JMPR, K_JCC, K_CALL, K_RET, K_PUSH, K_POP
  } op_kind_e;

  typedef enum logic [1:0] {SEL_C, SEL_Z, SEL_S, SEL_V} cond_sel_e;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [OPW-1:0] opcode_i,
  output op_kind_e       kind_o,
  output logic           one_byte_o,
  output cond_sel_e      sel_o,
  output logic           neg_o
);
  always_comb begin
    kind_o     = K_SEQ;
    one_byte_o = 1'b0;
    sel_o      = SEL_C;
    neg_o      = opcode_i[0];
    casez (opcode_i)
      8'h00: begin kind_o = K_HALT; one_byte_o = 1'b1; end
      8'h01: one_byte_o = 1'b1;
      8'h02: kind_o = K_JMPI;
      8'h03: kind_o = K_JMPR;
      8'h04, 8'h05: begin kind_o = K_JCC; sel_o = SEL_C; end
      8'h06, 8'h07: begin kind_o = K_JCC; sel_o = SEL_Z; end
      8'h0A, 8'h0B: begin kind_o = K_JCC; sel_o = SEL_S; end
      8'h0C, 8'h0D: begin kind_o = K_JCC; sel_o = SEL_V; end
      8'h0E: kind_o = K_CALL;
      8'h0F: begin kind_o = K_RET; one_byte_o = 1'b1; end
      8'b10100???, 8'b11010???: one_byte_o = 1'b1;
      8'b11100???: begin kind_o = K_PUSH; one_byte_o = 1'b1; end
      8'b11110???: begin kind_o = K_POP; one_byte_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcs_cond.sv
module pcs_cond
  import pcs_pkg::*;
(
  input  logic [7:0] flags_i,
  input  cond_sel_e  sel_i,
  input  logic       neg_i,
  output logic       take_o
);
  int unsigned idx;
  always_comb begin
    case (sel_i)
      SEL_C:   idx = FLAG_C;
      SEL_Z:   idx = FLAG_Z;
      SEL_S:   idx = FLAG_S;
      default: idx = FLAG_V;
    endcase
    take_o = flags_i[idx] ^ neg_i;
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         hold_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] addr_o,
  output logic         we_o,
  output logic [W-1:0] wdata_o
);
  localparam logic [W-1:0] SP_TOP = '1;
  localparam logic [W-1:0] ONE    = W'(1);

  logic [W-1:0] sp_q, sp_dec;

  assign sp_dec  = sp_q - ONE;
  assign addr_o  = push_i ? sp_dec : sp_q;
  // top address is the switch port, never RAM
  assign we_o    = push_i && !hold_i && (sp_dec != SP_TOP);
  assign wdata_o = push_data_i;
  assign sp_o    = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sp_q <= SP_TOP;
    else if (!hold_i && push_i) sp_q <= sp_dec;
    else if (!hold_i && pop_i)  sp_q <= sp_q + ONE;
  end
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   opcode_i,
  input  logic [W-1:0] operand_i,
  input  logic [7:0]   flags_i,
  input  logic [W-1:0] reg_val_i,
  input  logic [W-1:0] mem_rdata_i,
  input  logic [W-1:0] sw_i,
  output logic [2:0]   reg_idx_o,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] mem_addr_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_wdata_o,
  output logic [W-1:0] rd_data_o,
  output logic         halt_o
);
  localparam logic [W-1:0] PORT_ADDR = '1;
  localparam logic [RIW-1:0] SP_IDX  = '1;

  op_kind_e     kind;
  cond_sel_e    sel;
  logic         one_byte, neg, take, freeze, halt_q;
  logic [W-1:0] pc_q, pc_next, pc_seq, pc_ret_addr, reg_eff, sp_cur;

  pcs_decode i_decode (
    .opcode_i  (opcode_i),
    .kind_o    (kind),
    .one_byte_o(one_byte),
    .sel_o     (sel),
    .neg_o     (neg)
  );

  pcs_cond i_cond (
    .flags_i(flags_i),
    .sel_i  (sel),
    .neg_i  (neg),
    .take_o (take)
  );

  assign freeze      = halt_q || flags_i[FLAG_H] || (kind == K_HALT);
  assign reg_idx_o   = (kind == K_PUSH) ? opcode_i[RIW-1:0] : operand_i[RIW-1:0];
  assign reg_eff     = (reg_idx_o == SP_IDX) ? sp_cur : reg_val_i;
  assign pc_seq      = pc_q + (one_byte ? W'(1) : W'(2));
  assign pc_ret_addr = pc_q + W'(2);
  assign rd_data_o   = (mem_addr_o == PORT_ADDR) ? sw_i : mem_rdata_i;

  pcs_stack #(.W(W)) i_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     ((kind == K_CALL) || (kind == K_PUSH)),
    .pop_i      ((kind == K_RET) || (kind == K_POP)),
    .hold_i     (freeze),
    .push_data_i((kind == K_CALL) ? pc_ret_addr : reg_eff),
    .sp_o       (sp_cur),
    .addr_o     (mem_addr_o),
    .we_o       (mem_we_o),
    .wdata_o    (mem_wdata_o)
  );

  always_comb begin
    case (kind)
      K_JMPI, K_CALL: pc_next = operand_i;
      K_JMPR:         pc_next = reg_eff;
      K_JCC:          pc_next = take ? operand_i : pc_seq;
      K_RET:          pc_next = rd_data_o;
      default:        pc_next = pc_seq;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_q || freeze;
      if (!freeze) pc_q <= pc_next;
    end
  end

  assign pc_o   = pc_q;
  assign sp_o   = sp_cur;
  assign halt_o = freeze;
endmodule

// File: rtl/pcs_checks.sv
module pcs_checks #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [7:0]   opcode_i,
  input logic [W-1:0] pc_o,
  input logic [W-1:0] sp_o,
  input logic [W-1:0] mem_addr_o,
  input logic         mem_we_o,
  input logic         halt_o
);
  p_halt_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (pc_o == $past(pc_o)) && (sp_o == $past(sp_o)));
  p_halt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  p_halt_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_we_o);
  p_no_port_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o != '1));
  p_push_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(sp_o) - W'(1)));
  p_nop_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 8'h01 && !halt_o) |=> (pc_o == $past(pc_o) + W'(1)));
  p_hlt_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 8'h00) |-> halt_o);
endmodule

bind pc_stack_seq pcs_checks #(.W(W)) i_pcs_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .opcode_i  (opcode_i),
  .pc_o      (pc_o),
  .sp_o      (sp_o),
  .mem_addr_o(mem_addr_o),
  .mem_we_o  (mem_we_o),
  .halt_o    (halt_o)
);

// File: tb/test_pc_stack_seq.sv
module test_pc_stack_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SW_VAL = 8'h5A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] opcode = 8'h01, operand = 8'h00, flags = 8'h00;
  logic [7:0] reg_val, mem_rdata;
  logic [2:0] reg_idx;
  logic [7:0] pc, sp, mem_addr, mem_wdata, rd_data;
  logic mem_we, halt;
  logic [7:0] regs [8];
  logic [7:0] mem [255];
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_stack_seq i_pc_stack_seq (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .operand_i(operand),
    .flags_i(flags), .reg_val_i(reg_val), .mem_rdata_i(mem_rdata), .sw_i(SW_VAL),
    .reg_idx_o(reg_idx), .pc_o(pc), .sp_o(sp), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .rd_data_o(rd_data), .halt_o(halt)
  );

  assign reg_val   = regs[reg_idx];
  assign mem_rdata = (mem_addr == 8'hFF) ? 8'h00 : mem[mem_addr];

  always @(posedge clk) if (mem_we && mem_addr != 8'hFF) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; opcode = 8'h01; flags = 8'h00;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive at the falling edge, let combinational outputs settle
  task automatic issue(input logic [7:0] op, input logic [7:0] opnd, input logic [7:0] fl);
    @(negedge clk);
    opcode = op; operand = opnd; flags = fl;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic bit one_byte(input logic [7:0] op);
    return op == 8'h00 || op == 8'h01 || op == 8'h0F || op[7:3] == 5'b10100 ||
           op[7:3] == 5'b11010 || op[7:3] == 5'b11100 || op[7:3] == 5'b11110;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 8'h10 + 8'(i) * 8'h11;
    for (int i = 0; i < 255; i++) mem[i] = 8'(i) ^ 8'hA5;
    #(CLK_PERIOD + 2);
    rst_ni = 1'b1;
    #1;
    chk("R1 pc", pc, 8'h00);
    chk("R1 sp", sp, 8'hFF);
    chk("R1 halt", {7'b0, halt}, 8'h00);

    // sweep every opcode against every C/Z/S/V pattern from pc=0x40, sp=0xFF
    for (int o = 0; o < 256; o++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0] op, opnd, e_pc, e_sp, e_addr, e_wd;
        logic e_we, e_halt, take;
        logic [2:0] idx;
        op = 8'(o); opnd = 8'h98 + 8'(f);
        do_reset();
        issue(8'h02, 8'h40, 8'h00);
        tick();
        e_pc = 8'h40 + (one_byte(op) ? 8'd1 : 8'd2);
        e_sp = 8'hFF; e_we = 1'b0; e_addr = 8'hFF; e_wd = 8'h00; e_halt = 1'b0;
        take = 1'b0;
        case (op)
          8'h00: begin e_pc = 8'h40; e_halt = 1'b1; end
          8'h02: e_pc = opnd;
          8'h03: begin idx = opnd[2:0]; e_pc = (idx == 3'd7) ? 8'hFF : regs[idx]; end
          8'h04, 8'h05: take = f[3] ^ op[0];
          8'h06, 8'h07: take = f[2] ^ op[0];
          8'h0A, 8'h0B: take = f[1] ^ op[0];
          8'h0C, 8'h0D: take = f[0] ^ op[0];
          8'h0E: begin e_pc = opnd; e_sp = 8'hFE; e_we = 1'b1; e_addr = 8'hFE; e_wd = 8'h42; end
          8'h0F: begin e_pc = SW_VAL; e_sp = 8'h00; end
          default: ;
        endcase
        if (take) e_pc = opnd;
        if (op[7:3] == 5'b11100) begin
          idx = op[2:0];
          e_sp = 8'hFE; e_we = 1'b1; e_addr = 8'hFE;
          e_wd = (idx == 3'd7) ? 8'hFF : regs[idx];
        end
        if (op[7:3] == 5'b11110) e_sp = 8'h00;
        issue(op, opnd, {4'(f), 4'h0});
        chk("R9 halt_o", {7'b0, halt}, {7'b0, e_halt});
        chk("R5/R7 we", {7'b0, mem_we}, {7'b0, e_we});
        if (e_we) begin
          chk("R5/R7 addr", mem_addr, e_addr);
          chk("R5/R7 wdata", mem_wdata, e_wd);
        end
        if (op == 8'h0F || op[7:3] == 5'b11110) begin
          chk("R6/R8 rd addr", mem_addr, 8'hFF);
          chk("R8 port read", rd_data, SW_VAL);
        end
        tick();
        chk("R2/R3/R4 pc", pc, e_pc);
        chk("R5/R6/R7 sp", sp, e_sp);
      end
    end

    // R5/R6 nested call/return two deep
    do_reset();
    issue(8'h02, 8'h10, 8'h00); tick();
    issue(8'h0E, 8'h30, 8'h00);
    chk("R5 call1 addr", mem_addr, 8'hFE);
    chk("R5 call1 data", mem_wdata, 8'h12);
    tick();
    chk("R5 call1 pc", pc, 8'h30);
    issue(8'h0E, 8'h50, 8'h00);
    chk("R5 call2 addr", mem_addr, 8'hFD);
    chk("R5 call2 data", mem_wdata, 8'h32);
    tick();
    chk("R5 call2 sp", sp, 8'hFD);
    issue(8'h01, 8'h00, 8'h00); tick();
    chk("R2 nop pc", pc, 8'h51);
    issue(8'h0F, 8'h00, 8'h00);
    chk("R6 ret1 addr", mem_addr, 8'hFD);
    tick();
    chk("R6 ret1 pc", pc, 8'h32);
    chk("R6 ret1 sp", sp, 8'hFE);
    issue(8'h0F, 8'h00, 8'h00); tick();
    chk("R6 ret2 pc", pc, 8'h12);
    chk("R6 ret2 sp", sp, 8'hFF);

    // R7 push then pop of the same slot
    issue(8'hE2, 8'h00, 8'h00); tick();
    issue(8'hF5, 8'h00, 8'h00);
    chk("R7 pop addr", mem_addr, 8'hFE);
    chk("R7 pop data", rd_data, regs[2]);
    tick();
    chk("R7 pop sp", sp, 8'hFF);
    chk("R7 pc", pc, 8'h14);

    // R8 wrap: pop from empty stack, push onto the port address
    do_reset();
    issue(8'hF0, 8'h00, 8'h00); tick();
    chk("R8 wrap sp", sp, 8'h00);
    issue(8'hE1, 8'h00, 8'h00);
    chk("R8 no port write", {7'b0, mem_we}, 8'h00);
    chk("R8 push addr", mem_addr, 8'hFF);
    tick();
    chk("R8 push sp", sp, 8'hFF);
    issue(8'hF0, 8'h00, 8'h00);
    chk("R8 port after push", rd_data, SW_VAL);

    // R9 halt opcode freezes, sticky for later cycles
    do_reset();
    issue(8'h02, 8'h20, 8'h00); tick();
    issue(8'h00, 8'h00, 8'h00);
    chk("R9 halt now", {7'b0, halt}, 8'h01);
    tick();
    chk("R9 pc held", pc, 8'h20);
    for (int k = 0; k < 3; k++) begin
      issue(8'h01, 8'h00, 8'h00); tick();
      chk("R10 sticky pc", pc, 8'h20);
    end
    issue(8'h0E, 8'h77, 8'h00);
    chk("R10 no write", {7'b0, mem_we}, 8'h00);
    tick();
    chk("R10 sp held", sp, 8'hFF);

    // R10 halt via flags H, one cycle after the flags write
    do_reset();
    issue(8'h02, 8'h20, 8'h00); tick();
    issue(8'h01, 8'h00, 8'h00); tick();
    chk("R10 pre pc", pc, 8'h21);
    issue(8'h01, 8'h00, 8'h08);
    chk("R10 halt_o", {7'b0, halt}, 8'h01);
    tick();
    chk("R10 pc held", pc, 8'h21);
    issue(8'hE3, 8'h00, 8'h00);
    chk("R10 halt kept", {7'b0, halt}, 8'h01);
    chk("R10 push blocked", {7'b0, mem_we}, 8'h00);
    tick();
    chk("R10 pc after clear", pc, 8'h21);
    chk("R10 sp after clear", sp, 8'hFF);
    do_reset();
    #1;
    chk("R1 pc after halt", pc, 8'h00);
    chk("R1 halt cleared", {7'b0, halt}, 8'h00);

    finish_run();
  end
endmodule